// File: doc/BRIEF.md
# Dual-Channel Converter Port Adapter

This block connects host-side sample streams to a dual-channel baseband converter through two 12-bit buses, an upper bus and a lower bus. On the transmit side, the host offers channel A/B sample pairs on a valid/ready stream. The block places each pair onto the buses in the layout that the active mode selects. On the receive side, it reassembles the bus words into A/B pairs and presents each pair on the output for one cycle with `rx_valid`.

There are three layouts. In full-duplex, transmit words are interleaved on the upper bus with a separate sync line, while receive words arrive interleaved on the lower bus. In 12-bit half-duplex, one interleaved bus carries the data and the top line of the other bus carries the sync. In 24-bit half-duplex, both channels move in parallel on one cycle. A mode code and a direction input select the layout. A requested change is applied only when no transmit or receive pair is partly transferred.

Top module: `dual_conv_port`

## Requirements
- R1: While reset is asserted, the applied configuration is 12-bit half-duplex receive. All bus output enables, `tx_ready`, `rx_valid`, `sync_tx_o` and `frame_err` are low.
- R2: In full-duplex mode (`cfg_mode` = 0), transmit and receive run together, and the direction input is ignored. All upper-bus enables are high and all lower-bus enables are low. Receive words are read from `lo_i`, with `sync_rx_i` as the channel tag.
- R3: In interleaved transmit, the A word and sync = 1 appear on the outputs one cycle after the pair is accepted. The B word with sync = 0 appears the cycle after that.
- R4: In interleaved modes, `tx_ready` is low in the cycle that follows an acceptance. This caps the pair rate at one pair per two cycles, so the bus word rate is twice the per-channel rate.
- R5: In 12-bit half-duplex transmit (`cfg_mode` = 1, `cfg_tx_dir` = 1), the upper bus carries the interleaved words with all enables high. On the lower bus, only bit 11 is enabled, and that bit carries the sync.
- R6: In 12-bit half-duplex receive, words are read from `lo_i`, and `up_i` bit 11 is the sync (1 = channel A). A pair is delivered one cycle after its B word is sampled.
- R7: In 24-bit half-duplex transmit (`cfg_mode` = 2, `cfg_tx_dir` = 1), `tx_ready` is high on every cycle and both buses are fully enabled. Channel A goes to the upper bus and channel B to the lower bus, both registered one cycle after acceptance.
- R8: In 24-bit half-duplex receive, channel A is taken from `lo_i` and channel B from `up_i` on every cycle. The pair is delivered one cycle later.
- R9: In the half-duplex modes, a direction of 1 means transmit and 0 means receive. In receive, every bus output enable and `tx_ready` is low. In transmit, `rx_valid` stays low.
- R10: A B word (sync = 0) that arrives with no A word held is dropped without `rx_valid` and sets `frame_err`, which stays high until reset. A second A word replaces the held one.
- R11: A mode or direction change is applied only on a cycle where neither side holds half a pair. While the change is pending, `tx_ready` is low and no new receive pair is started. After the change, both sides start at channel A with idle outputs.
- R12: In transmit, a cycle with no word to send drives zero data and sync low.
- R13: Mode code 3 behaves exactly as mode code 1, and switching between these two codes is not a change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_mode | input | 2 | Layout request: 0 full-duplex, 1 or 3 12-bit half-duplex, 2 24-bit half-duplex |
| cfg_tx_dir | input | 1 | Half-duplex direction request, 1 transmit, 0 receive |
| tx_valid | input | 1 | Transmit pair offered |
| tx_ready | output | 1 | Transmit pair accepted this cycle when valid |
| tx_a | input | 12 | Channel A transmit sample |
| tx_b | input | 12 | Channel B transmit sample |
| rx_valid | output | 1 | Received pair present this cycle |
| rx_a | output | 12 | Channel A received sample |
| rx_b | output | 12 | Channel B received sample |
| frame_err | output | 1 | Sticky lone-B framing error |
| up_o | output | 12 | Upper bus drive value |
| up_oe | output | 12 | Upper bus per-line output enable |
| up_i | input | 12 | Upper bus sampled value |
| lo_o | output | 12 | Lower bus drive value |
| lo_oe | output | 12 | Lower bus per-line output enable |
| lo_i | input | 12 | Lower bus sampled value |
| sync_tx_o | output | 1 | Full-duplex transmit sync line |
| sync_rx_i | input | 1 | Full-duplex receive sync line |

## Verification
The assertions check properties that must hold on every cycle. They cover the order of A and B words with their sync values and the blocked ready during the B phase. They also check the parallel register stage, that a framing error stays set, that a lone B word never produces a pair, that the applied configuration holds between boundaries, and that no enable is raised in half-duplex receive. Other behaviours can only be shown by the bench's scenarios. These include the exact bus routing for each layout and the channel swap in 24-bit receive. They also include deferral of a change until a half-transferred pair completes, the idle data pattern, and the alias of mode code 3.

// File: rtl/dcp_pkg.sv
package dcp_pkg;

  typedef enum logic [1:0] {
    BUS_FD   = 2'd0,
    BUS_HD12 = 2'd1,
    BUS_HD24 = 2'd2
  } bus_mode_e;

  typedef struct packed {
    bus_mode_e mode;
    logic      tx_dir;
  } port_cfg_t;

  // Code 3 is an alias of the 12-bit half-duplex layout.
  function automatic bus_mode_e norm_mode(input logic [1:0] code);
    case (code)
      2'd0:    return BUS_FD;
      2'd2:    return BUS_HD24;
      default: return BUS_HD12;
    endcase
  endfunction

  function automatic logic mode_interleaved(input bus_mode_e m);
    return m != BUS_HD24;
  endfunction

  function automatic logic tx_enabled(input port_cfg_t c);
    return (c.mode == BUS_FD) || c.tx_dir;
  endfunction

  function automatic logic rx_enabled(input port_cfg_t c);
    return (c.mode == BUS_FD) || !c.tx_dir;
  endfunction

endpackage

// File: rtl/dcp_cfg_ctrl.sv
module dcp_cfg_ctrl
  import dcp_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic [1:0] mode_code,
  input  logic      dir_req,
  input  logic      tx_at_a,
  input  logic      rx_at_a,
  output port_cfg_t act,
  output logic      chg_pending
);

  port_cfg_t req;
  logic      chg_apply;

  always_comb begin
    req = '{mode: norm_mode(mode_code), tx_dir: dir_req};
  end

  assign chg_pending = (req != act);
  assign chg_apply   = chg_pending && tx_at_a && rx_at_a;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      act <= '{mode: BUS_HD12, tx_dir: 1'b0};
    end else if (chg_apply) begin
      act <= req;
    end
  end

  AST_CFG_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !chg_apply |=> $stable(act)); // R11
  AST_CFG_TAKE: assert property (@(posedge clk) disable iff (!rst_n)
    chg_apply |=> (act == $past(req))); // R11

endmodule

// File: rtl/dcp_tx_lane.sv
module dcp_tx_lane
  import dcp_pkg::*;
#(
  parameter int W = 12
) (
  input  logic         clk,
  input  logic         rst_n,
  input  port_cfg_t    act,
  input  logic         chg_pending,
  input  logic         tx_valid,
  output logic         tx_ready,
  input  logic [W-1:0] tx_a,
  input  logic [W-1:0] tx_b,
  output logic [W-1:0] word_hi,
  output logic [W-1:0] word_lo,
  output logic         sync_q,
  output logic         at_a
);

  logic         ph_b;
  logic [W-1:0] hold_b;
  logic         il;
  logic         active;
  logic         accept;

  assign il       = mode_interleaved(act.mode);
  assign active   = tx_enabled(act);
  assign tx_ready = active && !chg_pending && !ph_b;
  assign accept   = tx_valid && tx_ready;
  assign at_a     = !ph_b;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ph_b    <= 1'b0;
      hold_b  <= '0;
      word_hi <= '0;
      word_lo <= '0;
      sync_q  <= 1'b0;
    end else if (ph_b) begin
      word_hi <= hold_b;
      word_lo <= '0;
      sync_q  <= 1'b0;
      ph_b    <= 1'b0;
    end else if (accept && il) begin
      word_hi <= tx_a;
      word_lo <= '0;
      hold_b  <= tx_b;
      sync_q  <= 1'b1;
      ph_b    <= 1'b1;
    end else if (accept) begin
      word_hi <= tx_a;
      word_lo <= tx_b;
      sync_q  <= 1'b0;
    end else begin
      word_hi <= '0;
      word_lo <= '0;
      sync_q  <= 1'b0;
    end
  end

  AST_TX_A_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && il) |=> (sync_q && (word_hi == $past(tx_a)))); // R3
  AST_TX_B_NEXT: assert property (@(posedge clk) disable iff (!rst_n)
    ph_b |=> (!sync_q && (word_hi == $past(hold_b)))); // R3
  AST_TX_HALF_RATE: assert property (@(posedge clk) disable iff (!rst_n)
    ph_b |-> !tx_ready); // R4
  AST_TX_PARALLEL: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && !il) |=> ((word_hi == $past(tx_a)) && (word_lo == $past(tx_b)))); // R7
  AST_TX_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !active |-> !tx_ready); // R9

endmodule

// File: rtl/dcp_rx_lane.sv
module dcp_rx_lane
  import dcp_pkg::*;
#(
  parameter int W = 12
) (
  input  logic         clk,
  input  logic         rst_n,
  input  port_cfg_t    act,
  input  logic         chg_pending,
  input  logic [W-1:0] word,
  input  logic         sync,
  input  logic [W-1:0] par_a,
  input  logic [W-1:0] par_b,
  output logic         rx_valid,
  output logic [W-1:0] rx_a,
  output logic [W-1:0] rx_b,
  output logic         frame_err,
  output logic         at_a
);

  logic         ph_b;
  logic [W-1:0] hold_a;
  logic         il;
  logic         active;
  logic         take;
  logic         ev_a;
  logic         ev_b_ok;
  logic         ev_lone_b;
  logic         ev_par;

  assign il        = mode_interleaved(act.mode);
  assign active    = rx_enabled(act);
  // A pending change lets a started pair finish but starts no new one.
  assign take      = active && !(chg_pending && !ph_b);
  assign ev_a      = take && il && sync;
  assign ev_b_ok   = take && il && !sync && ph_b;
  assign ev_lone_b = take && il && !sync && !ph_b;
  assign ev_par    = take && !il;
  assign at_a      = !ph_b;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ph_b      <= 1'b0;
      hold_a    <= '0;
      rx_valid  <= 1'b0;
      rx_a      <= '0;
      rx_b      <= '0;
      frame_err <= 1'b0;
    end else begin
      rx_valid <= 1'b0;
      if (ev_a) begin
        hold_a <= word;
        ph_b   <= 1'b1;
      end
      if (ev_b_ok) begin
        rx_a     <= hold_a;
        rx_b     <= word;
        rx_valid <= 1'b1;
        ph_b     <= 1'b0;
      end
      if (ev_lone_b) begin
        frame_err <= 1'b1;
      end
      if (ev_par) begin
        rx_a     <= par_a;
        rx_b     <= par_b;
        rx_valid <= 1'b1;
      end
    end
  end

  AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    frame_err |=> frame_err); // R10
  AST_LONE_B_DROP: assert property (@(posedge clk) disable iff (!rst_n)
    ev_lone_b |=> (!rx_valid && frame_err)); // R10
  AST_PAIR_OUT: assert property (@(posedge clk) disable iff (!rst_n)
    ev_b_ok |=> (rx_valid && (rx_a == $past(hold_a)) && (rx_b == $past(word)))); // R6
  AST_RX_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
    !active |=> !rx_valid); // R9

endmodule

// File: rtl/dcp_bus_map.sv
module dcp_bus_map
  import dcp_pkg::*;
#(
  parameter int W = 12
) (
  input  port_cfg_t    act,
  input  logic [W-1:0] tx_hi,
  input  logic [W-1:0] tx_lo,
  input  logic         tx_sync,
  input  logic [W-1:0] up_i,
  input  logic [W-1:0] lo_i,
  input  logic         sync_rx_i,
  output logic [W-1:0] up_o,
  output logic [W-1:0] up_oe,
  output logic [W-1:0] lo_o,
  output logic [W-1:0] lo_oe,
  output logic         sync_tx_o,
  output logic [W-1:0] rx_word,
  output logic         rx_sync,
  output logic [W-1:0] rx_par_a,
  output logic [W-1:0] rx_par_b
);

  localparam int           SYNC_BIT = W - 1;
  localparam logic [W-1:0] ALL_ON   = '1;
  localparam logic [W-1:0] TOP_ONLY = {1'b1, {(W-1){1'b0}}};

  always_comb begin
    up_o      = '0;
    up_oe     = '0;
    lo_o      = '0;
    lo_oe     = '0;
    sync_tx_o = 1'b0;
    case (act.mode)
      BUS_FD: begin
        up_o      = tx_hi;
        up_oe     = ALL_ON;
        sync_tx_o = tx_sync;
      end
      BUS_HD24: begin
        if (act.tx_dir) begin
          up_o  = tx_hi;
          up_oe = ALL_ON;
          lo_o  = tx_lo;
          lo_oe = ALL_ON;
        end
      end
      default: begin
        if (act.tx_dir) begin
          up_o  = tx_hi;
          up_oe = ALL_ON;
          lo_o  = tx_sync ? TOP_ONLY : '0;
          lo_oe = TOP_ONLY;
        end
      end
    endcase
  end

  assign rx_word  = lo_i;
  assign rx_sync  = (act.mode == BUS_FD) ? sync_rx_i : up_i[SYNC_BIT];
  assign rx_par_a = lo_i;
  assign rx_par_b = up_i;

endmodule

// File: rtl/dual_conv_port.sv
module dual_conv_port
  import dcp_pkg::*;
#(
  parameter int W = 12
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [1:0]   cfg_mode,
  input  logic         cfg_tx_dir,
  input  logic         tx_valid,
  output logic         tx_ready,
  input  logic [W-1:0] tx_a,
  input  logic [W-1:0] tx_b,
  output logic         rx_valid,
  output logic [W-1:0] rx_a,
  output logic [W-1:0] rx_b,
  output logic         frame_err,
  output logic [W-1:0] up_o,
  output logic [W-1:0] up_oe,
  input  logic [W-1:0] up_i,
  output logic [W-1:0] lo_o,
  output logic [W-1:0] lo_oe,
  input  logic [W-1:0] lo_i,
  output logic         sync_tx_o,
  input  logic         sync_rx_i
);

  port_cfg_t    act;
  logic         chg_pending;
  logic         tx_at_a;
  logic         rx_at_a;
  logic [W-1:0] tx_hi;
  logic [W-1:0] tx_lo;
  logic         tx_sync;
  logic [W-1:0] rx_word;
  logic         rx_sync;
  logic [W-1:0] rx_par_a;
  logic [W-1:0] rx_par_b;

  dcp_cfg_ctrl u_cfg (
    .clk         (clk),
    .rst_n       (rst_n),
    .mode_code   (cfg_mode),
    .dir_req     (cfg_tx_dir),
    .tx_at_a     (tx_at_a),
    .rx_at_a     (rx_at_a),
    .act         (act),
    .chg_pending (chg_pending)
  );

  dcp_tx_lane #(.W(W)) u_tx (
    .clk         (clk),
    .rst_n       (rst_n),
    .act         (act),
    .chg_pending (chg_pending),
    .tx_valid    (tx_valid),
    .tx_ready    (tx_ready),
    .tx_a        (tx_a),
    .tx_b        (tx_b),
    .word_hi     (tx_hi),
    .word_lo     (tx_lo),
    .sync_q      (tx_sync),
    .at_a        (tx_at_a)
  );

  dcp_rx_lane #(.W(W)) u_rx (
    .clk         (clk),
    .rst_n       (rst_n),
    .act         (act),
    .chg_pending (chg_pending),
    .word        (rx_word),
    .sync        (rx_sync),
    .par_a       (rx_par_a),
    .par_b       (rx_par_b),
    .rx_valid    (rx_valid),
    .rx_a        (rx_a),
    .rx_b        (rx_b),
    .frame_err   (frame_err),
    .at_a        (rx_at_a)
  );

  dcp_bus_map #(.W(W)) u_map (
    .act       (act),
    .tx_hi     (tx_hi),
    .tx_lo     (tx_lo),
    .tx_sync   (tx_sync),
    .up_i      (up_i),
    .lo_i      (lo_i),
    .sync_rx_i (sync_rx_i),
    .up_o      (up_o),
    .up_oe     (up_oe),
    .lo_o      (lo_o),
    .lo_oe     (lo_oe),
    .sync_tx_o (sync_tx_o),
    .rx_word   (rx_word),
    .rx_sync   (rx_sync),
    .rx_par_a  (rx_par_a),
    .rx_par_b  (rx_par_b)
  );

  AST_HD_RX_NO_DRIVE: assert property (@(posedge clk) disable iff (!rst_n)
    ((act.mode != BUS_FD) && !act.tx_dir) |-> ((up_oe == '0) && (lo_oe == '0))); // R9
  AST_SYNC_PIN_FD_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
    (act.mode != BUS_FD) |-> !sync_tx_o); // R5

endmodule

// File: tb/test_dual_conv_port.sv
module test_dual_conv_port;

  localparam int W = 12;
  localparam logic [W-1:0] ALL_ON   = '1;
  localparam logic [W-1:0] TOP_ONLY = {1'b1, {(W-1){1'b0}}};

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic [1:0]   cfg_mode;
  logic         cfg_tx_dir;
  logic         tx_valid;
  logic         tx_ready;
  logic [W-1:0] tx_a, tx_b;
  logic         rx_valid;
  logic [W-1:0] rx_a, rx_b;
  logic         frame_err;
  logic [W-1:0] up_o, up_oe, up_i, lo_o, lo_oe, lo_i;
  logic         sync_tx_o, sync_rx_i;

  int errs = 0;
  int checks = 0;
  bit done = 0;

  always #10 clk = ~clk;

  dual_conv_port #(.W(W)) i_dual_conv_port (
    .clk(clk), .rst_n(rst_n), .cfg_mode(cfg_mode), .cfg_tx_dir(cfg_tx_dir),
    .tx_valid(tx_valid), .tx_ready(tx_ready), .tx_a(tx_a), .tx_b(tx_b),
    .rx_valid(rx_valid), .rx_a(rx_a), .rx_b(rx_b), .frame_err(frame_err),
    .up_o(up_o), .up_oe(up_oe), .up_i(up_i), .lo_o(lo_o), .lo_oe(lo_oe),
    .lo_i(lo_i), .sync_tx_o(sync_tx_o), .sync_rx_i(sync_rx_i)
  );

  // Expected enables {up_oe, lo_oe} per mode code and direction.
  function automatic logic [2*W-1:0] exp_oe(input int code, input bit dir);
    if (code == 0) return {ALL_ON, {W{1'b0}}};
    if (!dir) return '0;
    if (code == 2) return {ALL_ON, ALL_ON};
    return {ALL_ON, TOP_ONLY};
  endfunction

  // Expected lower bus value in 12-bit half-duplex transmit.
  function automatic logic [W-1:0] exp_sync_line(input bit s);
    return s ? TOP_ONLY : '0;
  endfunction

  task automatic chk(input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic tick;
    @(posedge clk);
    #5;
  endtask

  task automatic report;
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errs++;
      checks++;
      $display("FAIL watchdog: actual=running expected=finished");
      report();
    end
  end

  initial begin
    logic [W-1:0] a, b, ra, rb, q;
    bit send;
    void'($urandom(32'h5EED));
    cfg_mode = 2'd0; cfg_tx_dir = 1'b0; tx_valid = 1'b0; tx_a = '0; tx_b = '0;
    up_i = '0; lo_i = '0; sync_rx_i = 1'b0;
    repeat (3) @(posedge clk);
    #5;
    // R1 reset state
    chk("R1", "oe", {up_oe, lo_oe}, '0);
    chk("R1", "ready/valid/err/sync", {tx_ready, rx_valid, frame_err, sync_tx_o}, 4'b0);
    rst_n = 1'b1;
    tick();
    chk("R2", "fd enables", {up_oe, lo_oe}, exp_oe(0, 0));

    // Full-duplex, both directions together
    for (int i = 0; i < 40; i++) begin
      send = (i % 4) != 3;
      a = W'($urandom); b = W'($urandom); ra = W'($urandom); rb = W'($urandom);
      tx_valid = send; tx_a = a; tx_b = b; lo_i = ra; sync_rx_i = 1'b1;
      chk("R2", "ready at A", tx_ready, 1'b1);
      tick();
      if (send) begin
        chk("R3", "A word", {sync_tx_o, up_o}, {1'b1, a});
        chk("R4", "ready low", tx_ready, 1'b0);
      end else begin
        chk("R12", "idle fd", {sync_tx_o, up_o}, '0);
      end
      tx_a = ~a; lo_i = rb; sync_rx_i = 1'b0;
      tick();
      if (send) chk("R3", "B word", {sync_tx_o, up_o}, {1'b0, b});
      else      chk("R12", "idle fd 2", {sync_tx_o, up_o}, '0);
      chk("R2", "rx pair", {rx_valid, rx_a, rx_b}, {1'b1, ra, rb});
      tx_valid = 1'b0;
    end

    // R10 framing
    chk("R10", "err clear", frame_err, 1'b0);
    lo_i = W'($urandom); sync_rx_i = 1'b0;
    tick();
    chk("R10", "lone B", {rx_valid, frame_err}, 2'b01);
    lo_i = W'($urandom); sync_rx_i = 1'b1;
    tick();
    q = W'($urandom); lo_i = q;
    tick();
    chk("R10", "A then A", rx_valid, 1'b0);
    rb = W'($urandom); lo_i = rb; sync_rx_i = 1'b0;
    tick();
    chk("R10", "latest A kept", {rx_valid, rx_a, rx_b, frame_err}, {1'b1, q, rb, 1'b1});

    // R11 deferred change FD -> HD24 transmit
    a = W'($urandom); b = W'($urandom); ra = W'($urandom); rb = W'($urandom);
    tx_valid = 1'b1; tx_a = a; tx_b = b; lo_i = ra; sync_rx_i = 1'b1;
    tick();
    cfg_mode = 2'd2; cfg_tx_dir = 1'b1; lo_i = rb; sync_rx_i = 1'b0;
    tx_a = W'($urandom); tx_b = W'($urandom);
    chk("R11", "ready while pending", tx_ready, 1'b0);
    tick();
    chk("R11", "old layout kept", {lo_oe, sync_tx_o, up_o}, {{W{1'b0}}, 1'b0, b});
    chk("R11", "rx pair finished", {rx_valid, rx_a, rx_b}, {1'b1, ra, rb});
    sync_rx_i = 1'b1;
    chk("R11", "still pending", tx_ready, 1'b0);
    tick();
    chk("R11", "applied idle", {up_oe, lo_oe, up_o, lo_o}, {exp_oe(2, 1), {(2*W){1'b0}}});
    chk("R11", "no rx start", rx_valid, 1'b0);
    tx_valid = 1'b0;

    // R7 24-bit transmit
    for (int i = 0; i < 20; i++) begin
      send = ($urandom % 4) != 0;
      a = W'($urandom); b = W'($urandom);
      tx_valid = send; tx_a = a; tx_b = b;
      chk("R7", "ready each cycle", tx_ready, 1'b1);
      tick();
      chk("R7", "parallel", {up_o, lo_o}, send ? {a, b} : '0);
      chk("R5", "no sync pin", sync_tx_o, 1'b0);
    end

    // R8 24-bit receive
    cfg_tx_dir = 1'b0; tx_valid = 1'b1;
    tick();
    chk("R9", "rx no drive", {up_oe, lo_oe}, exp_oe(2, 0));
    chk("R9", "rx no ready", tx_ready, 1'b0);
    tx_valid = 1'b0;
    for (int i = 0; i < 20; i++) begin
      ra = W'($urandom); rb = W'($urandom);
      lo_i = ra; up_i = rb;
      tick();
      chk("R8", "swap", {rx_valid, rx_a, rx_b}, {1'b1, ra, rb});
    end

    // R5 12-bit transmit
    cfg_mode = 2'd1; cfg_tx_dir = 1'b1;
    tick();
    chk("R5", "enables", {up_oe, lo_oe}, exp_oe(1, 1));
    for (int i = 0; i < 20; i++) begin
      send = (i % 5) != 2;
      a = W'($urandom); b = W'($urandom);
      tx_valid = send; tx_a = a; tx_b = b;
      tick();
      chk("R5", "A + sync", {up_o, lo_o}, send ? {a, exp_sync_line(1)} : '0);
      chk("R9", "tx no rx", rx_valid, 1'b0);
      tick();
      chk("R5", "B + sync", {up_o, lo_o}, send ? {b, exp_sync_line(0)} : '0);
      tx_valid = 1'b0;
    end

    // R13 alias code
    cfg_mode = 2'd3;
    tick();
    chk("R13", "alias no change", {up_oe, lo_oe, tx_ready}, {exp_oe(3, 1), 1'b1});
    a = W'($urandom); tx_valid = 1'b1; tx_a = a;
    tick();
    chk("R13", "alias tx", {up_o, lo_o}, {a, TOP_ONLY});
    tx_valid = 1'b0;
    tick();

    // R6 12-bit receive
    cfg_tx_dir = 1'b0;
    tick();
    chk("R9", "hd12 rx no drive", {up_oe, lo_oe}, '0);
    for (int i = 0; i < 20; i++) begin
      ra = W'($urandom); rb = W'($urandom);
      lo_i = ra; up_i = {1'b1, (W-1)'($urandom)};
      tick();
      chk("R6", "after A", rx_valid, 1'b0);
      lo_i = rb; up_i = {1'b0, (W-1)'($urandom)};
      tick();
      chk("R6", "pair", {rx_valid, rx_a, rx_b}, {1'b1, ra, rb});
    end

    // R1 reset clears sticky error
    rst_n = 1'b0;
    tick();
    chk("R1", "reset clears", {frame_err, up_oe, lo_oe}, '0);

    done = 1;
    report();
  end

endmodule